// File: doc/BRIEF.md
# Prescaled Watchdog Match Timer

This block is a watchdog timer reached over a simple single-cycle register bus. A prescale counter divides the clock. Each time the prescale counter wraps it issues a tick, and the tick advances a timer counter. Two compare channels each hold a match value. When a channel matches the counter on a tick, it latches a flag. It can also clear the counter, halt counting by dropping the enable bit, and drive its own external match pin low, high or to the opposite level.

Software programs the prescale limit, the match values and the per-channel actions, then sets the enable bit. If software does not keep the counter away from the match values, a matching channel with its request enable set raises `reset_req`. The request stays high until software clears the flag by writing 1 to its bit.

Register words by byte offset: 0x00 flags, 0x04 control, 0x08 timer counter, 0x0C prescale limit, 0x10 prescale counter, 0x14 match actions, 0x18 match value 0, 0x1C match value 1, 0x3C external pin control. Offsets 0x20 to 0x38 are reserved. A read presents data combinationally in the same cycle. A write takes effect at the next rising clock edge.

Top module: `wdog_match_timer`

## Requirements
- R1: After synchronous reset every register reads 0, and `ext_match` and `reset_req` are 0.
- R2: While control bit 0 (enable) is 1, the prescale counter (0x10) increments on each clock. In a cycle where it equals the prescale limit (0x0C), a tick occurs: the prescale counter returns to 0 and the timer counter (0x08) increments by one.
- R3: While enable is 0, neither counter changes except by a bus write. While control bit 1 is 1, each tick loads the timer counter with 0, and no match is recognised.
- R4: A channel matches on a tick when the timer counter equals its match value (0x18 for channel 0, 0x1C for channel 1) and control bit 1 is 0. The match sets flag bit 0 or 1 of register 0x00.
- R5: A match on channel 0 with action bit 1 set, or on channel 1 with action bit 4 set, loads the timer counter with 0 on that tick. This clear takes priority over a stop.
- R6: A match on channel 0 with action bit 2 set, or on channel 1 with action bit 5 set, keeps the timer counter at its value and clears enable. Counting stays frozen until software writes enable again.
- R7: External pin control bits 5:4 select the action of pin 0 on a channel 0 match, and bits 7:6 select the action of pin 1 on a channel 1 match. The codes are 00 keep, 01 low, 10 high, 11 toggle. Bits 1:0 read and write the pin levels, which drive `ext_match`. On a pin whose channel matches with a non-zero code in the same cycle, the match action takes priority over the written level.
- R8: `reset_req` is 1 exactly when flag 0 is set with action bit 0 set, or flag 1 is set with action bit 3 set.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A match in the same cycle leaves the flag set.
- R10: Reads of offsets 0x20 to 0x38 return 0, and writes to them change no register.
- R11: A bus write to the timer counter or to the prescale counter takes priority over counting in the same cycle. A write to the control register cannot set enable in the cycle where a stop action fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ext_match | output | 2 | External match pin levels |
| reset_req | output | 1 | Watchdog reset/interrupt request |

## Verification
The hardest situations to reach from the ports are collisions in a single cycle. One is a flag-clear write arriving on the tick where the same channel matches. Another is a control write in the cycle where a stop fires. A third is both channels matching together with conflicting clear and stop actions. The stimulus makes these likely by keeping prescale limits, match values and counter loads small, so that ticks and matches come every few cycles. Random writes to every register then land on those cycles often, and a bench model recomputes every register and pin each cycle.

// File: rtl/wdm_pkg.sv
// Package: shared word indices and the external pin action encoding
// for the prescaled watchdog match timer. Assumes 32-bit bus words.
package wdm_pkg;
    localparam int BUS_W = 32;
    localparam int NCH   = 2;

    localparam logic [3:0] IDX_FLAGS = 4'd0;
    localparam logic [3:0] IDX_CTRL  = 4'd1;
    localparam logic [3:0] IDX_TC    = 4'd2;
    localparam logic [3:0] IDX_PRE   = 4'd3;
    localparam logic [3:0] IDX_PC    = 4'd4;
    localparam logic [3:0] IDX_ACT   = 4'd5;
    localparam logic [3:0] IDX_MV0   = 4'd6;
    localparam logic [3:0] IDX_MV1   = 4'd7;
    localparam logic [3:0] IDX_PINS  = 4'd15;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'b00,
        PIN_LOW    = 2'b01,
        PIN_HIGH   = 2'b10,
        PIN_TOGGLE = 2'b11
    } pin_act_e;
endpackage

// File: rtl/wdm_prescaler.sv
// Module: wdm_prescaler
// Divides the clock. The count advances each cycle while run is high and
// wraps to zero in the cycle it equals limit; that cycle raises tick.
// Assumes a bus load (ld) wins over counting; tick still reflects the old count.
module wdm_prescaler #(
    parameter int PS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] limit,
    input  logic            ld,
    input  logic [PS_W-1:0] ld_val,
    output logic [PS_W-1:0] pc,
    output logic            tick
);
    // Tick: enabled and the count has reached the limit.
    assign tick = run && (pc == limit);

    // Prescale count register: load, wrap or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (ld) begin
            pc <= ld_val;
        end else if (run) begin
            pc <= tick ? '0 : pc + 1'b1;
        end
    end
endmodule

// File: rtl/wdm_channel.sv
// Module: wdm_channel
// One compare channel: recognises a match on a tick while the counter is
// not held in reset, and owns the level of its external match pin.
// Assumes a match with a non-keep action wins over a bus write of the level.
module wdm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic [CNT_W-1:0] tc,
    input  logic [CNT_W-1:0] mv,
    input  wdm_pkg::pin_act_e act,
    input  logic             lvl_we,
    input  logic             lvl_wd,
    output logic             match,
    output logic             level
);
    import wdm_pkg::*;

    // Match detect: only on a tick, and never while the counter is held.
    assign match = tick && !hold && (tc == mv);

    // Pin level register: match action first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
        end else if (match && act != PIN_KEEP) begin
            unique case (act)
                PIN_LOW:    level <= 1'b0;
                PIN_HIGH:   level <= 1'b1;
                default:    level <= ~level;
            endcase
        end else if (lvl_we) begin
            level <= lvl_wd;
        end
    end
endmodule

// File: rtl/wdog_match_timer.sv
// Module: wdog_match_timer (top)
// Register file, timer counter, latched match flags and request output of
// the prescaled watchdog match timer. Single-cycle bus: reads are
// combinational, writes land on the next rising edge. Assumes CNT_W and
// PS_W are at most 32.
module wdog_match_timer #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [1:0]  ext_match,
    output logic        reset_req
);
    import wdm_pkg::*;

    logic [3:0]       widx;
    logic             wr_any;
    logic             run_en, hold_rst;
    logic [CNT_W-1:0] tc_q;
    logic [PS_W-1:0]  pr_q, pc_q;
    logic             tick;
    logic [5:0]       mcr_q;
    logic [1:0]       flags_q;
    logic [CNT_W-1:0] mv_q [NCH];
    pin_act_e         act_q [NCH];
    logic [NCH-1:0]   match_v, lvl_v, clr_en, stop_en, req_en;
    logic             clr_any, stop_any;

    assign widx   = bus_addr[5:2];
    assign wr_any = bus_sel && bus_wr;

    // Per-channel action enables from the match action register.
    assign req_en  = {mcr_q[3], mcr_q[0]};
    assign clr_en  = {mcr_q[4], mcr_q[1]};
    assign stop_en = {mcr_q[5], mcr_q[2]};
    assign clr_any  = |(match_v & clr_en);
    assign stop_any = |(match_v & stop_en);

    wdm_prescaler #(.PS_W(PS_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .limit  (pr_q),
        .ld     (wr_any && widx == IDX_PC),
        .ld_val (bus_wdata[PS_W-1:0]),
        .pc     (pc_q),
        .tick   (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        wdm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .hold   (hold_rst),
            .tc     (tc_q),
            .mv     (mv_q[g]),
            .act    (act_q[g]),
            .lvl_we (wr_any && widx == IDX_PINS),
            .lvl_wd (bus_wdata[g]),
            .match  (match_v[g]),
            .level  (lvl_v[g])
        );
    end

    // Timer counter: bus write, then reset/clear, then stop-hold, then count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= '0;
        end else if (wr_any && widx == IDX_TC) begin
            tc_q <= bus_wdata[CNT_W-1:0];
        end else if (tick) begin
            if (hold_rst || clr_any) tc_q <= '0;
            else if (!stop_any)      tc_q <= tc_q + 1'b1;
        end
    end

    // Control bits: a firing stop always leaves enable cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            hold_rst <= 1'b0;
        end else if (wr_any && widx == IDX_CTRL) begin
            run_en   <= bus_wdata[0] && !stop_any;
            hold_rst <= bus_wdata[1];
        end else if (stop_any) begin
            run_en   <= 1'b0;
        end
    end

    // Match flags: write-one-to-clear, a new match always sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~((wr_any && widx == IDX_FLAGS) ? bus_wdata[1:0] : 2'b00))
                       | match_v;
        end
    end

    // Plain configuration registers written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q  <= '0;
            mcr_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                mv_q[i]  <= '0;
                act_q[i] <= PIN_KEEP;
            end
        end else if (wr_any) begin
            unique case (widx)
                IDX_PRE:  pr_q     <= bus_wdata[PS_W-1:0];
                IDX_ACT:  mcr_q    <= bus_wdata[5:0];
                IDX_MV0:  mv_q[0]  <= bus_wdata[CNT_W-1:0];
                IDX_MV1:  mv_q[1]  <= bus_wdata[CNT_W-1:0];
                IDX_PINS: begin
                    act_q[0] <= pin_act_e'(bus_wdata[5:4]);
                    act_q[1] <= pin_act_e'(bus_wdata[7:6]);
                end
                default: ;
            endcase
        end
    end

    // Read mux: reserved and unmapped words return zero.
    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            IDX_FLAGS: bus_rdata = 32'(flags_q);
            IDX_CTRL:  bus_rdata = 32'({hold_rst, run_en});
            IDX_TC:    bus_rdata = 32'(tc_q);
            IDX_PRE:   bus_rdata = 32'(pr_q);
            IDX_PC:    bus_rdata = 32'(pc_q);
            IDX_ACT:   bus_rdata = 32'(mcr_q);
            IDX_MV0:   bus_rdata = 32'(mv_q[0]);
            IDX_MV1:   bus_rdata = 32'(mv_q[1]);
            IDX_PINS:  bus_rdata = 32'({act_q[1], act_q[0], 2'b00, lvl_v});
            default:   bus_rdata = '0;
        endcase
    end

    assign ext_match = lvl_v;
    assign reset_req = |(flags_q & req_en);
endmodule

// File: rtl/wdm_checker.sv
// Module: wdm_checker
// Temporal properties of the watchdog match timer, bound to the top.
// Assumes it observes the top's internal counter and flag state.
module wdm_checker #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [5:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             reset_req,
    input logic             run_en,
    input logic [CNT_W-1:0] tc_q,
    input logic [PS_W-1:0]  pc_q,
    input logic [PS_W-1:0]  pr_q,
    input logic [5:0]       mcr_q,
    input logic [1:0]       match_v,
    input logic [1:0]       flags_q
);
    logic wr_any, wr_tc, wr_pc, rd_resv;
    assign wr_any  = bus_sel && bus_wr;
    assign wr_tc   = wr_any && bus_addr[5:2] == 4'd2;
    assign wr_pc   = wr_any && bus_addr[5:2] == 4'd4;
    assign rd_resv = bus_sel && !bus_wr && bus_addr[5:2] >= 4'd8 && bus_addr[5:2] <= 4'd14;

    p_pc_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && pc_q == pr_q && !wr_pc) |=> pc_q == '0);

    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_any) |=> ($stable(tc_q) && $stable(pc_q)));

    p_flag0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_v[0] |=> flags_q[0]);

    p_flag1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_v[1] |=> flags_q[1]);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((match_v[0] && mcr_q[1]) || (match_v[1] && mcr_q[4])) && !wr_tc) |=> tc_q == '0);

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((match_v[0] && mcr_q[2]) || (match_v[1] && mcr_q[5])) |=> !run_en);

    p_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (flags_q != 2'b00));

    p_resv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resv |-> bus_rdata == 32'd0);
endmodule

bind wdog_match_timer wdm_checker #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .reset_req (reset_req),
    .run_en    (run_en),
    .tc_q      (tc_q),
    .pc_q      (pc_q),
    .pr_q      (pr_q),
    .mcr_q     (mcr_q),
    .match_v   (match_v),
    .flags_q   (flags_q)
);

// File: tb/sim_wdog_match_timer.sv
`timescale 1ns/1ps
// Bench: random and directed bus traffic against a cycle model of the
// register-level requirements; compares pins every cycle and read data.
module sim_wdog_match_timer;
    localparam int CW = 16;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ext_match;
    logic        reset_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_match_timer #(.CNT_W(CW), .PS_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_match(ext_match), .reset_req(reset_req)
    );

    // Model state
    logic          m_en, m_hold;
    logic [CW-1:0] m_tc, m_mv0, m_mv1;
    logic [PW-1:0] m_pr, m_pc;
    logic [5:0]    m_mcr;
    logic [1:0]    m_fl, m_lvl, m_act0, m_act1;

    task automatic model_reset();
        m_en = 0; m_hold = 0; m_tc = '0; m_mv0 = '0; m_mv1 = '0;
        m_pr = '0; m_pc = '0; m_mcr = '0; m_fl = '0; m_lvl = '0;
        m_act0 = '0; m_act1 = '0;
    endtask

    function automatic logic [31:0] model_read(input logic [5:0] a);
        case (a[5:2])
            4'd0:  return 32'(m_fl);
            4'd1:  return 32'({m_hold, m_en});
            4'd2:  return 32'(m_tc);
            4'd3:  return 32'(m_pr);
            4'd4:  return 32'(m_pc);
            4'd5:  return 32'(m_mcr);
            4'd6:  return 32'(m_mv0);
            4'd7:  return 32'(m_mv1);
            4'd15: return 32'({m_act1, m_act0, 2'b00, m_lvl});
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a[5:2])
            4'd0: return "R9";
            4'd1: return "R3";
            4'd2, 4'd3, 4'd4: return "R2";
            4'd5, 4'd6, 4'd7: return "R4";
            4'd15: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step(input logic s, input logic w, input logic [5:0] a, input logic [31:0] d);
        logic tick, clr, stp;
        logic [1:0] mt, hw;
        logic [1:0] code [2];
        logic          n_en, n_hold;
        logic [CW-1:0] n_tc;
        logic [PW-1:0] n_pc;
        logic [1:0]    n_fl, n_lvl;
        tick = m_en && (m_pc == m_pr);
        mt[0] = tick && !m_hold && (m_tc == m_mv0);
        mt[1] = tick && !m_hold && (m_tc == m_mv1);
        clr = (mt[0] && m_mcr[1]) || (mt[1] && m_mcr[4]);
        stp = (mt[0] && m_mcr[2]) || (mt[1] && m_mcr[5]);
        n_pc = m_en ? (tick ? '0 : m_pc + 1'b1) : m_pc;
        n_tc = m_tc;
        if (tick) begin
            if (m_hold || clr) n_tc = '0;
            else if (!stp)     n_tc = m_tc + 1'b1;
        end
        n_en = stp ? 1'b0 : m_en;
        n_hold = m_hold;
        n_fl = m_fl | mt;
        code[0] = m_act0; code[1] = m_act1;
        n_lvl = m_lvl;
        for (int i = 0; i < 2; i++) begin
            hw[i] = mt[i] && code[i] != 2'b00;
            if (hw[i]) n_lvl[i] = (code[i] == 2'b01) ? 1'b0 : (code[i] == 2'b10) ? 1'b1 : ~m_lvl[i];
        end
        if (s && w) begin
            case (a[5:2])
                4'd0: n_fl = (m_fl & ~d[1:0]) | mt;
                4'd1: begin n_en = d[0] && !stp; n_hold = d[1]; end
                4'd2: n_tc = d[CW-1:0];
                4'd3: m_pr = d[PW-1:0];
                4'd4: n_pc = d[PW-1:0];
                4'd5: m_mcr = d[5:0];
                4'd6: m_mv0 = d[CW-1:0];
                4'd7: m_mv1 = d[CW-1:0];
                4'd15: begin
                    m_act0 = d[5:4]; m_act1 = d[7:6];
                    for (int i = 0; i < 2; i++) if (!hw[i]) n_lvl[i] = d[i];
                end
                default: ;
            endcase
        end
        m_en = n_en; m_hold = n_hold; m_tc = n_tc; m_pc = n_pc;
        m_fl = n_fl; m_lvl = n_lvl;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, check, then advance model at posedge.
    task automatic cyc(input logic s, input logic w, input logic [5:0] a, input logic [31:0] d, input string tag);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        check("R7 ext_match", 32'(ext_match), 32'(m_lvl));
        check("R8 reset_req", 32'(reset_req), 32'(|(m_fl & {m_mcr[3], m_mcr[0]})));
        if (s && !w) check((tag == "") ? tag_of(a) : tag, bus_rdata, model_read(a));
        @(posedge clk);
        model_step(s, w, a, d);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, "");
    endtask
    task automatic rd(input logic [5:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 32'd0, tag);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 6'd0, 32'd0, "");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd4242);
        model_reset();
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values across the map
        for (int k = 0; k < 16; k++) rd(6'(k * 4), "R1");

        // R2, R4, R5, R7: prescale 2, channel 0 clears at 5, toggles pin 0, raises request
        wr(6'h0C, 2);
        wr(6'h18, 5);
        wr(6'h14, 32'h03);
        wr(6'h3C, 32'h30);
        wr(6'h04, 1);
        idle(40);
        rd(6'h08, "R5");
        rd(6'h00, "R4");
        // R9: write-one clears flag
        wr(6'h00, 3);
        rd(6'h00, "R9");
        // R6: stop on channel 1 at 3, pin 1 driven high
        wr(6'h1C, 3);
        wr(6'h14, 32'h20);
        wr(6'h3C, 32'h80);
        wr(6'h08, 0);
        wr(6'h04, 1);
        idle(30);
        rd(6'h04, "R6");
        rd(6'h08, "R6");
        idle(5);
        rd(6'h08, "R3");
        // R3: counter held in reset
        wr(6'h04, 3);
        idle(12);
        rd(6'h08, "R3");
        // R10: reserved write ignored, reserved read zero
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h38, 32'hFFFF_FFFF);
        rd(6'h20, "R10");
        rd(6'h38, "R10");
        for (int k = 0; k < 8; k++) rd(6'(k * 4), "R10");
        // R11: counter writes while counting
        wr(6'h04, 1);
        wr(6'h10, 1);
        wr(6'h08, 9);
        rd(6'h08, "R11");

        // Random phase: small values so ticks and matches collide with writes
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [5:0] a;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            a = {4'($urandom_range(0, 15)), 2'b00};
            if (op < 4) begin
                idle(1);
            end else if (op < 6) begin
                rd(a, "");
            end else begin
                case (a[5:2])
                    4'd1: d = ($urandom_range(0, 3) != 0) ? 32'd1 : 32'($urandom_range(0, 3));
                    4'd3: d = 32'($urandom_range(0, 3));
                    4'd5: d = 32'($urandom_range(0, 63));
                    4'd15: d = 32'($urandom_range(0, 255));
                    default: d = 32'($urandom_range(0, 15));
                endcase
                if (a[5:2] >= 4'd8 && a[5:2] <= 4'd14) d = $urandom;
                wr(a, d);
            end
        end
        for (int k = 0; k < 16; k++) rd(6'(k * 4), "");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule